// File: doc/BRIEF.md
# Sequential Signed Arithmetic Unit

This block does 32-bit two's-complement addition, subtraction, multiplication and division. A controller pulses `start` and waits for `done`. The opcode and both operands are captured on the clock edge at which `start` is seen high while the unit is idle. Addition, subtraction and the no-effect codes complete on the next edge. Multiplication and division run through a bit-serial core, one bit per cycle, and finish a fixed number of cycles later. On every completion, `result` holds the new value in the same cycle that `done` is high.

Multiplication uses shift-and-add on operand magnitudes and keeps the low word of the product. Division uses restoring shift-subtract on operand magnitudes and rounds the quotient toward zero. Both cores apply the sign at the end. Reset is synchronous and active low.

Top module: `seq_alu`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after that edge, `done` is 0 and `result` is 0.
- R2: Opcode 1 (add) sampled with `start` high in idle gives `result` = low 32 bits of `op_a + op_b` and `done` = 1 in the cycle right after that edge.
- R3: Opcode 2 (subtract) behaves as R2 with `result` = low 32 bits of `op_a - op_b`.
- R4: Opcode 3 (multiply) gives the low 32 bits of the signed product. `done` rises WIDTH+1 edges after the accepting edge.
- R5: Opcode 4 (divide) gives the signed quotient rounded toward zero. Its sign is the XOR of the operand signs, and -2^31 / -1 wraps to -2^31. Timing is as R4.
- R6: Divide with `op_b` = 0 completes with the same timing as R5 and returns all ones.
- R7: Opcode 0 (no operation), opcode 5 (end marker) and the unused codes 6 and 7 leave `result` unchanged and raise `done` in the cycle after acceptance.
- R8: While a multiply or divide is running, `start`, `opcode` and the operands are ignored. No extra completion occurs and the result uses only the captured values.
- R9: `result` changes only in a cycle where `done` is 1. `done` is high for exactly one cycle per accepted operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request strobe, sampled in idle |
| opcode | input | 3 | Operation code (0 nop, 1 add, 2 sub, 3 mul, 4 div, 5 end) |
| op_a | input | 32 | First operand, signed |
| op_b | input | 32 | Second operand, signed |
| result | output | 32 | Signed result register |
| done | output | 1 | One-cycle completion flag |

## Verification
The bench targets the division sign corners: every mix of negative dividend and divisor, plus results that must round toward zero. A core that fixes the sign wrongly or rounds toward minus infinity returns -2 instead of -1 for -5/3, or +43 for -153156/3543. Multiply cases push set bits past bit 31, so a core that saturates or keeps high bits returns something other than 0 or 160. The bench also covers divide by zero with a negative dividend, where a sign fix-up applied after the all-ones value yields +1. Finally, it toggles `start` and the operands mid-operation and holds `start` high across a completion; a controller that re-arms early shows up as an extra `done` or a result built from the altered operands.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ADD = 3'd1,
    OP_SUB = 3'd2,
    OP_MUL = 3'd3,
    OP_DIV = 3'd4,
    OP_END = 3'd5
  } alu_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } alu_state_e;
endpackage

// File: rtl/alu_mul_core.sv
module alu_mul_core #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             fin_o,
  output logic [WIDTH-1:0] res_o
);
  localparam int CW = $clog2(WIDTH + 1);

  logic             busy;
  logic [CW-1:0]    cnt;
  logic [WIDTH-1:0] mcand, mplier, acc;
  logic             neg;
  logic             fin;

  function automatic logic [WIDTH-1:0] magnitude(input logic [WIDTH-1:0] v);
    return v[WIDTH-1] ? (~v + 1'b1) : v;
  endfunction

  function automatic logic [WIDTH-1:0] apply_sign(input logic [WIDTH-1:0] v, input logic n);
    return n ? (~v + 1'b1) : v;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      mcand  <= '0;
      mplier <= '0;
      acc    <= '0;
      neg    <= 1'b0;
      fin    <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (load) begin
        mcand  <= magnitude(a_i);
        mplier <= magnitude(b_i);
        acc    <= '0;
        neg    <= a_i[WIDTH-1] ^ b_i[WIDTH-1];
        cnt    <= CW'(WIDTH);
        busy   <= 1'b1;
      end else if (busy) begin
        if (mplier[0]) acc <= acc + mcand;
        mcand  <= mcand << 1;
        mplier <= mplier >> 1;
        cnt    <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end
    end
  end

  assign fin_o = fin;
  assign res_o = apply_sign(acc, neg);

  // R4
  mul_fin_single_chk: assert property (@(posedge clk) disable iff (!rst_n) fin |=> !fin);
  // R4
  mul_cnt_live_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |-> (cnt != '0));
endmodule

// File: rtl/alu_div_core.sv
module alu_div_core #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             fin_o,
  output logic [WIDTH-1:0] res_o
);
  localparam int CW = $clog2(WIDTH + 1);

  logic             busy;
  logic [CW-1:0]    cnt;
  logic [WIDTH-1:0] rem, quo, dvs;
  logic             neg, dz;
  logic             fin;
  logic [WIDTH:0]   trial;
  logic             fits;

  function automatic logic [WIDTH-1:0] magnitude(input logic [WIDTH-1:0] v);
    return v[WIDTH-1] ? (~v + 1'b1) : v;
  endfunction

  function automatic logic [WIDTH-1:0] apply_sign(input logic [WIDTH-1:0] v, input logic n);
    return n ? (~v + 1'b1) : v;
  endfunction

  assign trial = {rem, quo[WIDTH-1]};
  assign fits  = trial >= {1'b0, dvs};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      rem  <= '0;
      quo  <= '0;
      dvs  <= '0;
      neg  <= 1'b0;
      dz   <= 1'b0;
      fin  <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (load) begin
        rem  <= '0;
        quo  <= magnitude(a_i);
        dvs  <= magnitude(b_i);
        neg  <= a_i[WIDTH-1] ^ b_i[WIDTH-1];
        dz   <= (b_i == '0);
        cnt  <= CW'(WIDTH);
        busy <= 1'b1;
      end else if (busy) begin
        rem  <= fits ? WIDTH'(trial - {1'b0, dvs}) : trial[WIDTH-1:0];
        quo  <= {quo[WIDTH-2:0], fits};
        cnt  <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end
    end
  end

  assign fin_o = fin;
  assign res_o = dz ? '1 : apply_sign(quo, neg);

  // R5
  div_fin_single_chk: assert property (@(posedge clk) disable iff (!rst_n) fin |=> !fin);
  // R5
  div_rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) (busy && !dz) |-> (rem < dvs));
endmodule

// File: rtl/seq_alu.sv
module seq_alu #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       opcode,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic [WIDTH-1:0] result,
  output logic             done
);
  import alu_pkg::*;

  alu_state_e       state;
  alu_op_e          op;
  logic             accept, is_long, mul_load, div_load;
  logic             mul_fin, div_fin, core_fin;
  logic [WIDTH-1:0] mul_res, div_res;

  assign op       = alu_op_e'(opcode);
  assign accept   = (state == ST_IDLE) && start;
  assign is_long  = (op == OP_MUL) || (op == OP_DIV);
  assign mul_load = accept && (op == OP_MUL);
  assign div_load = accept && (op == OP_DIV);
  assign core_fin = mul_fin || div_fin;

  alu_mul_core #(.WIDTH(WIDTH)) u_mul (
    .clk(clk), .rst_n(rst_n), .load(mul_load),
    .a_i(op_a), .b_i(op_b), .fin_o(mul_fin), .res_o(mul_res)
  );

  alu_div_core #(.WIDTH(WIDTH)) u_div (
    .clk(clk), .rst_n(rst_n), .load(div_load),
    .a_i(op_a), .b_i(op_b), .fin_o(div_fin), .res_o(div_res)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            case (op)
              OP_ADD: begin result <= op_a + op_b; done <= 1'b1; end
              OP_SUB: begin result <= op_a - op_b; done <= 1'b1; end
              OP_MUL, OP_DIV: state <= ST_WAIT;
              default: done <= 1'b1;
            endcase
          end
        end
        ST_WAIT: begin
          if (mul_fin) begin
            result <= mul_res;
            done   <= 1'b1;
            state  <= ST_IDLE;
          end else if (div_fin) begin
            result <= div_res;
            done   <= 1'b1;
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  fast_done_chk: assert property (@(posedge clk) disable iff (!rst_n) (accept && !is_long) |=> done);
  // R7
  nop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !is_long && (op != OP_ADD) && (op != OP_SUB)) |=> $stable(result));
  // R4
  long_no_early_done_chk: assert property (@(posedge clk) disable iff (!rst_n) (accept && is_long) |=> !done);
  // R8
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_WAIT) && !core_fin) |=> (!done && (state == ST_WAIT)));
  // R9
  result_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n) !$stable(result) |-> done);
  // R9
  fin_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n) !(mul_fin && div_fin));
endmodule

// File: tb/tb_seq_alu.sv
module tb_seq_alu;
  localparam int W = 32;
  localparam logic [2:0] C_NOP = 3'd0, C_ADD = 3'd1, C_SUB = 3'd2,
                         C_MUL = 3'd3, C_DIV = 3'd4, C_END = 3'd5;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [2:0]   opcode;
  logic [W-1:0] op_a, op_b;
  logic [W-1:0] result;
  logic         done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  seq_alu #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .op_a(op_a), .op_b(op_b), .result(result), .done(done)
  );

  always #4 clk = ~clk;

  // Behavioural reference model
  int unsigned  m_cnt = 0;
  logic [W-1:0] m_res = '0;
  logic [W-1:0] m_pend = '0;
  bit           m_done = 0;
  string        m_tag = "R1";

  function automatic logic [W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    longint p;
    p = longint'($signed(a)) * longint'($signed(b));
    return p[W-1:0];
  endfunction

  function automatic logic [W-1:0] ref_div(input logic [W-1:0] a, input logic [W-1:0] b);
    longint q;
    if (b == '0) return '1;
    q = longint'($signed(a)) / longint'($signed(b));
    return q[W-1:0];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_res = '0; m_done = 0; m_tag = "R1";
    end else begin
      m_done = 0;
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin m_done = 1; m_res = m_pend; end
      end else if (start) begin
        case (opcode)
          C_ADD: begin m_res = op_a + op_b; m_done = 1; m_tag = "R2"; end
          C_SUB: begin m_res = op_a - op_b; m_done = 1; m_tag = "R3"; end
          C_MUL: begin m_pend = ref_mul(op_a, op_b); m_cnt = W + 1; m_tag = "R4"; end
          C_DIV: begin
            m_pend = ref_div(op_a, op_b); m_cnt = W + 1;
            m_tag = (op_b == '0) ? "R6" : "R5";
          end
          default: begin m_done = 1; m_tag = "R7"; end
        endcase
      end
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !finished) begin
      checks++;
      if (done !== m_done || result !== m_res) begin
        errors++;
        $display("FAIL %s/R9 cycle %0d: done=%0b result=%0d expected done=%0b result=%0d",
                 m_tag, cyc, done, $signed(result), m_done, $signed(m_res));
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wait_done();
    int guard = 0;
    while (done !== 1'b1 && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
  endtask

  task automatic run(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    opcode = op; op_a = a; op_b = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    op_a = ~a; op_b = b ^ 32'h5A5A_0001; opcode = C_ADD;
    wait_done();
  endtask

  // R8: disturb inputs while a long operation runs
  task automatic run_disturbed(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    opcode = op; op_a = a; op_b = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      start = i[0]; opcode = 3'(i); op_a = 32'(i * 77); op_b = 32'(i + 3);
      @(negedge clk);
    end
    start = 1'b0;
    wait_done();
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; opcode = C_NOP; op_a = '0; op_b = '0;
    repeat (4) @(negedge clk);
    checks++;
    if (done !== 1'b0 || result !== '0) begin
      errors++;
      $display("FAIL R1 in reset: done=%0b result=%0d expected 0 0", done, result);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (done !== 1'b0 || result !== '0) begin
      errors++;
      $display("FAIL R1 after reset: done=%0b result=%0d expected 0 0", done, result);
    end

    // R2 / R3 add and subtract, including wrap
    run(C_ADD, 32'sd7, 32'sd3);
    run(C_SUB, 32'sd7, 32'sd1);
    run(C_ADD, 32'h7FFF_FFFF, 32'sd1);
    run(C_SUB, 32'sd0, 32'sd1);
    run(C_SUB, 32'h8000_0000, 32'sd1);
    // R7 no-effect codes hold result
    run(C_NOP, 32'sd99, 32'sd1);
    run(C_END, 32'sd5, 32'sd5);
    run(3'd7, 32'sd5, 32'sd5);
    // R4 multiply, low word wrap
    run(C_MUL, 32'sd7, 32'sd3);
    run(C_MUL, -32'sd7, 32'sd3);
    run(C_MUL, 32'sd268435456, -32'sd2);
    run(C_MUL, 32'sd268435456, 32'sd32);
    run(C_MUL, 32'sd268435461, 32'sd32);
    run(C_MUL, -32'sd1, -32'sd1);
    run(C_MUL, 32'h8000_0000, -32'sd1);
    // R5 divide, truncation and sign
    run(C_DIV, -32'sd5, 32'sd3);
    run(C_DIV, 32'sd7, 32'sd1);
    run(C_DIV, 32'sd7, 32'sd3);
    run(C_DIV, 32'sd100, 32'sd10);
    run(C_DIV, 32'sd100, 32'sd51);
    run(C_DIV, 32'sd100, 32'sd49);
    run(C_DIV, 32'sd153156, 32'sd3543);
    run(C_DIV, -32'sd153156, 32'sd3543);
    run(C_DIV, 32'sd153156, -32'sd3543);
    run(C_DIV, -32'sd153156, -32'sd3543);
    run(C_DIV, 32'h8000_0000, -32'sd1);
    run(C_DIV, 32'h8000_0000, 32'sd7);
    run(C_DIV, 32'sd3, 32'sd7);
    // R6 divide by zero
    run(C_DIV, 32'sd12345, 32'sd0);
    run(C_DIV, -32'sd12345, 32'sd0);
    // R8 ignored inputs while busy
    run_disturbed(C_MUL, -32'sd1234, 32'sd567);
    run_disturbed(C_DIV, 32'sd1000000, -32'sd7);
    // R9 start held high across completions
    @(negedge clk);
    opcode = C_ADD; op_a = 32'sd20; op_b = 32'sd22; start = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    opcode = C_MUL; op_a = 32'sd6; op_b = -32'sd9; start = 1'b1;
    repeat (40) @(negedge clk);
    start = 1'b0;
    wait_done();
    repeat (40) @(negedge clk);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule